// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects eleven interrupt sources and presents the most urgent one to a processor core. Six sources arrive on active-low chip pins: three can be set per pin to edge or level sensing, two always sense level, and one always senses a falling edge. Five more arrive as single-cycle pulses from on-chip logic: power-down, serial transmit, serial receive, byte DMA and timer. A software force input can raise any of the eleven directly. Latched requests stay pending until the core acknowledges them by source index; level requests follow their pin.

A configuration write loads a per-source enable mask, the sensing mode of the three programmable pins and a global enable. The power-down request ignores both the mask and the global enable. The winner is chosen by fixed priority: the lower the source index, the higher the priority. The core receives a request flag, the 4-bit source index and a vector address of four times the index. Index 0 belongs to reset and is never granted.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every pending latch, the mask, the edge-mode bits and the global enable clear. After that edge, `irq` is 0 and `irq_idx` and `irq_vec` are 0 until a new request arrives.
- R2: Source indices are: 1 power-down, 2 programmable pin 0, 3 level pin 1, 4 level pin 0, 5 serial transmit, 6 serial receive, 7 edge pin, 8 byte DMA, 9 programmable pin 1, 10 programmable pin 2, 11 timer. Among enabled pending sources, the lowest index is granted.
- R3: `irq_vec` equals `irq_idx` times 4. With nothing granted, `irq` is 0 and both outputs are 0.
- R4: A level-sensed pin requests while it is low and is not latched. Its request appears after the second rising edge following the fall and drops after the second rising edge following the rise.
- R5: A falling edge on the edge pin (`epin_n`) is latched and shows after the third rising edge. It stays pending after the pin goes high again.
- R6: `cfg_edge` bit k set to 1 makes programmable pin k edge-sensed (bit 0 to index 2, bit 1 to index 9, bit 2 to index 10). Set to 0, the pin is level-sensed.
- R7: A one-cycle pulse on an internal event input is latched at the next rising edge and shows after that edge.
- R8: An `ack` with `ack_idx` = n clears only the latch of source n. A request arriving for the same source in the same cycle is kept. An acknowledge does not remove a level request whose pin is still low.
- R9: `cfg_mask` bit (n-1) set to 1 enables source n. A masked source is not granted, but its latch is kept and is granted once the mask bit is set.
- R10: With `cfg_gie` at 0, no maskable source is granted. Power-down (index 1) is granted whatever the mask and global enable hold.
- R11: `sw_force` bit (n-1) latches a request for source n at the next edge, for a source of any kind.
- R12: A cycle with `cfg_we` high loads mask, edge mode and global enable, and the new values act from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xpin_n | input | 3 | Programmable-sense pins, active low |
| lpin_n | input | 2 | Level-sensed pins, active low |
| epin_n | input | 1 | Edge-sensed pin, falling edge |
| pd_evt | input | 1 | Power-down request pulse |
| stx_evt | input | 1 | Serial transmit done pulse |
| srx_evt | input | 1 | Serial receive done pulse |
| dma_evt | input | 1 | Byte DMA done pulse |
| tmr_evt | input | 1 | Timer expiry pulse |
| sw_force | input | 11 | Software request, bit n-1 for source n |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_mask | input | 11 | Per-source enable, bit n-1 for source n |
| cfg_edge | input | 3 | Edge-mode select per programmable pin |
| cfg_gie | input | 1 | Global enable for maskable sources |
| ack | input | 1 | Core acknowledge |
| ack_idx | input | 4 | Index of the acknowledged source |
| irq | output | 1 | Request to the core |
| irq_idx | output | 4 | Granted source index |
| irq_vec | output | 6 | Granted vector address |

## Verification
A latch that sticks or clears at the wrong time shows on `irq_idx` at the next edge. It either keeps presenting an acknowledged source or gives up one that was never acknowledged, so every acknowledge is followed by a check of the next granted index. A synchronizer stage that is too short or too long moves the first cycle `irq` rises by one edge, so pin tests sample on both sides of the expected edge. A wrong priority order or enable gating shows as a different index while several sources are pending together. Those stacks are built so each acknowledge reveals the next source in line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_SRC  = 11;
    localparam int IDX_W    = 4;
    localparam int VEC_W    = IDX_W + 2;
    localparam int NUM_PROG = 3;
    localparam int NUM_LVL  = 2;
    localparam int NUM_PIN  = NUM_PROG + NUM_LVL + 1;

    // pin vector layout: programmable pins, then level pins, then the edge pin
    localparam int PIN_LVL0 = NUM_PROG;
    localparam int PIN_LVL1 = NUM_PROG + 1;
    localparam int PIN_EDGE = NUM_PROG + NUM_LVL;

    // slot = source index - 1; the order fixes the priority
    localparam int SLOT_PD   = 0;
    localparam int SLOT_STX  = 4;
    localparam int SLOT_SRX  = 5;
    localparam int SLOT_DMA  = 7;
    localparam int SLOT_TMR  = 10;

    typedef enum logic [1:0] {
        SRC_INTERNAL,
        SRC_PROG,
        SRC_LEVEL,
        SRC_EDGE
    } src_kind_e;

    typedef struct packed {
        logic [NUM_SRC-1:0]  mask;
        logic [NUM_PROG-1:0] edge_sel;
        logic                gie;
    } irqc_cfg_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [VEC_W-1:0] vec;
    } irqc_grant_t;

    function automatic src_kind_e src_kind(int slot);
        case (slot)
            1, 8, 9: return SRC_PROG;
            2, 3:    return SRC_LEVEL;
            6:       return SRC_EDGE;
            default: return SRC_INTERNAL;
        endcase
    endfunction

    function automatic int src_pin(int slot);
        case (slot)
            1:       return 0;
            8:       return 1;
            9:       return 2;
            2:       return PIN_LVL1;
            3:       return PIN_LVL0;
            6:       return PIN_EDGE;
            default: return 0;
        endcase
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(logic [IDX_W-1:0] idx);
        return {idx, 2'b00};
    endfunction

    // slots whose index is smaller (higher priority) than idx
    function automatic logic [NUM_SRC-1:0] above_of(logic [IDX_W-1:0] idx);
        logic [NUM_SRC-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SRC; s++)
            if (IDX_W'(s + 1) < idx) m[s] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irqc_pin_sync.sv
module irqc_pin_sync
    import irqc_pkg::*;
#(
    parameter int N = NUM_PIN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_n,
    output logic [N-1:0] active,
    output logic [N-1:0] fall
);

    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '1;
            sync_q <= '1;
            prev_q <= '1;
        end else begin
            meta_q <= pin_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign active = ~sync_q;
    assign fall   = prev_q & ~sync_q;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ((fall & $past(fall)) == '0));  // R5

endmodule

// File: rtl/irqc_pend.sv
module irqc_pend
    import irqc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= set | (q & ~clr);
    end

    AST_SET_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (($past(set) & ~q) == '0));  // R11

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ((q & $past(clr & ~set)) == '0));  // R8

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0] req,
    output irqc_grant_t  grant
);

    always_comb begin
        grant = '0;
        for (int s = N - 1; s >= 0; s--) begin
            if (req[s]) begin
                grant.valid = 1'b1;
                grant.idx   = IDX_W'(s + 1);
            end
        end
        grant.vec = vec_of(grant.idx);
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PROG-1:0] xpin_n,
    input  logic [NUM_LVL-1:0]  lpin_n,
    input  logic                epin_n,
    input  logic                pd_evt,
    input  logic                stx_evt,
    input  logic                srx_evt,
    input  logic                dma_evt,
    input  logic                tmr_evt,
    input  logic [NUM_SRC-1:0]  sw_force,
    input  logic                cfg_we,
    input  logic [NUM_SRC-1:0]  cfg_mask,
    input  logic [NUM_PROG-1:0] cfg_edge,
    input  logic                cfg_gie,
    input  logic                ack,
    input  logic [IDX_W-1:0]    ack_idx,
    output logic                irq,
    output logic [IDX_W-1:0]    irq_idx,
    output logic [VEC_W-1:0]    irq_vec
);

    irqc_cfg_t          cfg_q;
    logic [NUM_PIN-1:0] pins_n;
    logic [NUM_PIN-1:0] pin_act;
    logic [NUM_PIN-1:0] pin_fall;
    logic [NUM_SRC-1:0] int_evt;
    logic [NUM_SRC-1:0] set_hw;
    logic [NUM_SRC-1:0] lvl_req;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] latched;
    logic [NUM_SRC-1:0] enable;
    logic [NUM_SRC-1:0] eligible;
    irqc_grant_t        grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.mask     <= cfg_mask;
            cfg_q.edge_sel <= cfg_edge;
            cfg_q.gie      <= cfg_gie;
        end
    end

    assign pins_n = {epin_n, lpin_n, xpin_n};

    irqc_pin_sync #(.N(NUM_PIN)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_n  (pins_n),
        .active (pin_act),
        .fall   (pin_fall)
    );

    always_comb begin
        int_evt           = '0;
        int_evt[SLOT_PD]  = pd_evt;
        int_evt[SLOT_STX] = stx_evt;
        int_evt[SLOT_SRX] = srx_evt;
        int_evt[SLOT_DMA] = dma_evt;
        int_evt[SLOT_TMR] = tmr_evt;
    end

    // per-source request path chosen by the source kind
    always_comb begin
        for (int s = 0; s < NUM_SRC; s++) begin
            set_hw[s]  = 1'b0;
            lvl_req[s] = 1'b0;
            case (src_kind(s))
                SRC_PROG: begin
                    set_hw[s]  = pin_fall[src_pin(s)] & cfg_q.edge_sel[src_pin(s)];
                    lvl_req[s] = pin_act[src_pin(s)] & ~cfg_q.edge_sel[src_pin(s)];
                end
                SRC_LEVEL: lvl_req[s] = pin_act[src_pin(s)];
                SRC_EDGE:  set_hw[s]  = pin_fall[src_pin(s)];
                default:   set_hw[s]  = int_evt[s];
            endcase
            clr[s] = ack && (ack_idx == IDX_W'(s + 1));
        end
    end

    irqc_pend #(.N(NUM_SRC)) u_pend (
        .clk (clk),
        .rst (rst),
        .set (set_hw | sw_force),
        .clr (clr),
        .q   (latched)
    );

    always_comb begin
        enable          = cfg_q.mask & {NUM_SRC{cfg_q.gie}};
        enable[SLOT_PD] = 1'b1;
        eligible        = (latched | lvl_req) & enable;
    end

    irqc_prio #(.N(NUM_SRC)) u_prio (
        .req   (eligible),
        .grant (grant)
    );

    assign irq     = grant.valid;
    assign irq_idx = grant.idx;
    assign irq_vec = grant.vec;

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !irq);  // R1

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (irq_idx == '0 && irq_vec == '0));  // R3

    AST_HIGHEST_WINS: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((eligible & above_of(irq_idx)) == '0
                 && eligible[irq_idx - 1'b1]));  // R2

    AST_PD_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        latched[SLOT_PD] |-> (irq && irq_idx == IDX_W'(SLOT_PD + 1)));  // R10

    AST_GIE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.gie && !latched[SLOT_PD]) |-> !irq);  // R10

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
    import irqc_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NUM_PROG-1:0] xpin_n = '1;
    logic [NUM_LVL-1:0]  lpin_n = '1;
    logic                epin_n = 1'b1;
    logic                pd_evt = 1'b0, stx_evt = 1'b0, srx_evt = 1'b0;
    logic                dma_evt = 1'b0, tmr_evt = 1'b0;
    logic [NUM_SRC-1:0]  sw_force = '0;
    logic                cfg_we = 1'b0;
    logic [NUM_SRC-1:0]  cfg_mask = '0;
    logic [NUM_PROG-1:0] cfg_edge = '0;
    logic                cfg_gie = 1'b0;
    logic                ack = 1'b0;
    logic [IDX_W-1:0]    ack_idx = '0;
    logic                irq;
    logic [IDX_W-1:0]    irq_idx;
    logic [VEC_W-1:0]    irq_vec;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [NUM_SRC-1:0] ALL = '1;

    always #2.5 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk, .rst, .xpin_n, .lpin_n, .epin_n,
        .pd_evt, .stx_evt, .srx_evt, .dma_evt, .tmr_evt,
        .sw_force, .cfg_we, .cfg_mask, .cfg_edge, .cfg_gie,
        .ack, .ack_idx, .irq, .irq_idx, .irq_vec
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic e_irq, int e_idx);
        n_tests++;
        if (irq !== e_irq || irq_idx !== IDX_W'(e_idx) || irq_vec !== VEC_W'(e_idx * 4)) begin
            n_fail++;
            $display("FAIL %s: irq=%0b idx=%0d vec=%0d expected irq=%0b idx=%0d vec=%0d",
                     req, irq, irq_idx, irq_vec, e_irq, e_idx, e_idx * 4);
        end
    endtask

    task automatic load_cfg(logic [NUM_SRC-1:0] m, logic [NUM_PROG-1:0] e, logic g);
        cfg_mask = m; cfg_edge = e; cfg_gie = g; cfg_we = 1'b1;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic do_ack(int idx);
        ack = 1'b1; ack_idx = IDX_W'(idx);
        step(1);
        ack = 1'b0;
    endtask

    task automatic t_reset;
        step(1);
        rst = 1'b0;
        step(1);
        chk("R1 idle after reset", 1'b0, 0);
        lpin_n[0] = 1'b0;
        step(3);
        chk("R1 mask cleared by reset", 1'b0, 0);
        load_cfg(ALL, '0, 1'b1);
        chk("R12 config takes effect", 1'b1, 4);
        lpin_n[0] = 1'b1;
        step(2);
        chk("R4 level release", 1'b0, 0);
    endtask

    task automatic t_level;
        lpin_n[1] = 1'b0;
        step(1);
        chk("R4 not yet after one edge", 1'b0, 0);
        step(1);
        chk("R4 level after two edges", 1'b1, 3);
        lpin_n[0] = 1'b0;
        step(2);
        chk("R2 index 3 over 4", 1'b1, 3);
        lpin_n[1] = 1'b1;
        step(2);
        chk("R4 next level shown", 1'b1, 4);
        lpin_n[0] = 1'b1;
        step(1);
        chk("R4 held one edge after rise", 1'b1, 4);
        step(1);
        chk("R4 dropped two edges after rise", 1'b0, 0);
    endtask

    task automatic t_edge;
        epin_n = 1'b0;
        step(2);
        chk("R5 not yet after two edges", 1'b0, 0);
        step(1);
        chk("R5 edge after three edges", 1'b1, 7);
        epin_n = 1'b1;
        step(3);
        chk("R5 stays after pin high", 1'b1, 7);
        do_ack(7);
        chk("R8 ack clears edge latch", 1'b0, 0);
    endtask

    task automatic t_prog;
        load_cfg(ALL, 3'b010, 1'b1);
        xpin_n[1] = 1'b0;
        step(3);
        chk("R6 pin1 edge mode", 1'b1, 9);
        xpin_n[1] = 1'b1;
        step(3);
        chk("R6 pin1 latched", 1'b1, 9);
        do_ack(9);
        chk("R8 pin1 cleared", 1'b0, 0);
        xpin_n[2] = 1'b0;
        step(2);
        chk("R6 pin2 level mode", 1'b1, 10);
        xpin_n[2] = 1'b1;
        step(2);
        chk("R6 pin2 follows pin", 1'b0, 0);
        xpin_n[0] = 1'b0;
        step(2);
        chk("R6 pin0 level mode", 1'b1, 2);
        do_ack(2);
        chk("R8 ack keeps asserted level", 1'b1, 2);
        xpin_n[0] = 1'b1;
        step(2);
        chk("R6 pin0 released", 1'b0, 0);
    endtask

    task automatic t_prio;
        load_cfg(ALL, '0, 1'b1);
        tmr_evt = 1'b1; dma_evt = 1'b1; stx_evt = 1'b1;
        step(1);
        tmr_evt = 1'b0; dma_evt = 1'b0; stx_evt = 1'b0;
        chk("R7 R2 serial tx first", 1'b1, 5);
        do_ack(5);
        chk("R2 byte DMA next", 1'b1, 8);
        do_ack(8);
        chk("R2 timer last", 1'b1, 11);
        srx_evt = 1'b1;
        step(1);
        srx_evt = 1'b0;
        chk("R7 serial rx above timer", 1'b1, 6);
        do_ack(6);
        do_ack(11);
        chk("R8 all acknowledged", 1'b0, 0);
    endtask

    task automatic t_mask;
        load_cfg(ALL & ~(NUM_SRC'(1) << SLOT_TMR), '0, 1'b1);
        tmr_evt = 1'b1;
        step(1);
        tmr_evt = 1'b0;
        chk("R9 masked timer hidden", 1'b0, 0);
        load_cfg(ALL, '0, 1'b1);
        chk("R9 latch kept while masked", 1'b1, 11);
        do_ack(11);
        chk("R9 timer cleared", 1'b0, 0);
    endtask

    task automatic t_pd;
        load_cfg('0, '0, 1'b0);
        pd_evt = 1'b1;
        step(1);
        pd_evt = 1'b0;
        chk("R10 power-down ignores mask and enable", 1'b1, 1);
        dma_evt = 1'b1;
        step(1);
        dma_evt = 1'b0;
        chk("R10 power-down on top", 1'b1, 1);
        do_ack(1);
        chk("R10 global enable off hides DMA", 1'b0, 0);
        load_cfg(ALL, '0, 1'b1);
        chk("R9 DMA shown after enable", 1'b1, 8);
        do_ack(8);
        chk("R8 DMA cleared", 1'b0, 0);
    endtask

    task automatic t_sw;
        sw_force = NUM_SRC'(1) << 2;
        step(1);
        sw_force = '0;
        chk("R11 force on level slot", 1'b1, 3);
        do_ack(3);
        chk("R11 forced latch cleared", 1'b0, 0);
        sw_force = NUM_SRC'(1) << 6;
        step(1);
        sw_force = '0;
        chk("R11 force on edge slot", 1'b1, 7);
        do_ack(7);
        chk("R11 edge slot cleared", 1'b0, 0);
    endtask

    task automatic t_ack_race;
        tmr_evt = 1'b1;
        step(1);
        tmr_evt = 1'b0;
        chk("R7 timer latched", 1'b1, 11);
        tmr_evt = 1'b1; ack = 1'b1; ack_idx = IDX_W'(11);
        step(1);
        tmr_evt = 1'b0; ack = 1'b0;
        chk("R8 new request wins over ack", 1'b1, 11);
        do_ack(5);
        chk("R8 other index leaves timer", 1'b1, 11);
        do_ack(11);
        chk("R8 timer cleared", 1'b0, 0);
    endtask

    initial begin
        t_reset();
        t_level();
        t_edge();
        t_prog();
        t_prio();
        t_mask();
        t_pd();
        t_sw();
        t_ack_race();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule